// File: doc/BRIEF.md
# Watchdog Timer with Start-up Disable Window

This block supervises a small processor system. After the system's internal reset sequence reports completion, a 16-bit up-counter advances once every two system clocks. If software fails to service the timer before the counter wraps past its all-ones value, the block raises a one-cycle reset request for the system. At the same moment it latches a sticky flag that tells start-up code that the last reset came from the watchdog.

Three command strobes come from the processor: service, end-of-initialization and disable. Disable is honoured only during a short start-up window. The window opens with every reset and shuts for good on the first service or end-of-initialization. Service reloads the counter from an 8-bit reload register, placed in the upper byte above a zero lower byte. A separate write port updates that register without disturbing the running count.

When the block issues its own reset request, it also returns its internal state to the post-reset condition. Counting then resumes as soon as the internal-reset-done input is high.

Top module: `wdg_top`

## Requirements
- R1: While the block has not started, the count holds and no reset request is made. The block starts on the first clock edge with `int_done` high. After an external reset the count reads 0x0000.
- R2: Once started and not disabled, the count increases by exactly one on every second clock edge. At the negedge following the n-th edge after the start edge, it reads floor(n/2).
- R3: From a start with reload 0x00, the reset request appears directly after the 131072nd clock edge following the start edge.
- R4: `rst_req` is high for exactly one cycle, and `cause_flag` is 1 whenever it is high. In that cycle the count reads 0x0000, the reload register is back to 0x00, the disable window is open and the block is enabled. The block restarts on the next edge at which `int_done` is high.
- R5: `cause_flag` is cleared by a service command accepted while started, and by external reset. End-of-initialization does not clear it, and neither does the block's own restart.
- R6: An accepted service loads the count with {reload, 0x00}. The next reset request then follows 2*(65536 - 256*reload) clock edges after the service edge.
- R7: A write to the reload register does not change the running count.
- R8: A disable accepted inside the window freezes the count and blocks all reset requests until the next reset. A service while disabled still reloads the count and clears the flag, but the block stays frozen.
- R9: After a service or end-of-initialization has been accepted, disable has no effect until the next reset.
- R10: A disable in the same cycle as a service or end-of-initialization is ignored.
- R11: If a service arrives on the edge where the counter would wrap, the service wins. No request is made and the count reloads.
- R12: Commands given before the block has started are ignored. For example, a service before start leaves `cause_flag` unchanged.
- R13: An active-low `ext_rst_n` clears the count, the flag, the request, the disabled state and the reload register, and it reopens the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | External hardware reset, active low, asynchronous |
| int_done | input | 1 | High once the internal reset sequence has completed |
| svc_stb | input | 1 | Service command strobe, one cycle |
| einit_stb | input | 1 | End-of-initialization command strobe, one cycle |
| dis_stb | input | 1 | Disable command strobe, one cycle |
| reload_we | input | 1 | Write enable for the reload register |
| reload_val | input | 8 | New reload value |
| rst_req | output | 1 | One-cycle system reset request on overflow |
| cause_flag | output | 1 | Sticky flag: last reset came from this watchdog |
| count | output | 16 | Current counter value |

## Verification
The hardest situation to produce is a service that lands exactly on the wrapping tick, because the service must hit one specific edge out of two in the prescaler phase. The stimulus loads reload 0xFF so the wrap comes 512 edges after a service. It counts edges from that service and raises the next service so that it is sampled on edge 512. Two further cases are reached by letting the block overflow while `int_done` stays high: an open disable window after a self-triggered restart, and a 131072-edge run from reload zero, which is driven once in full.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    WDG_IDLE = 2'd0,
    WDG_RUN  = 2'd1,
    WDG_OFF  = 2'd2
  } wdg_phase_e;

  // Counter value produced by a reload: reload value shifted above a zero field.
  function automatic logic [31:0] wdg_seed(input logic [31:0] rl, input int low_w);
    return rl << low_w;
  endfunction

  // True when the counter sits at its last value before wrapping.
  function automatic logic wdg_at_top(input logic [31:0] cnt, input int cnt_w);
    logic [31:0] top;
    top = (cnt_w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << cnt_w) - 32'd1);
    return cnt == top;
  endfunction

endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);

  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_div
      logic [PW-1:0] ph_q;
      logic          last_ph;

      assign last_ph = (ph_q == PW'(DIV - 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ph_q <= '0;
        end else if (!run || clear || last_ph) begin
          ph_q <= '0;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end

      assign tick = run && last_ph;

      // R2: ticks never come on back-to-back edges
      assert_half_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/wdg_permit.sv
module wdg_permit
  import wdg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic int_done,
  input  logic svc_stb,
  input  logic einit_stb,
  input  logic dis_stb,
  input  logic fire,
  output logic started,
  output logic disabled,
  output logic window_open,
  output logic svc_ok,
  output logic run
);

  wdg_phase_e phase_q;
  logic       win_q;
  logic       close_win;

  assign started     = (phase_q != WDG_IDLE);
  assign disabled    = (phase_q == WDG_OFF);
  assign run         = (phase_q == WDG_RUN);
  assign window_open = win_q;
  assign svc_ok      = svc_stb && started;
  assign close_win   = (svc_stb || einit_stb) && started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= WDG_IDLE;
      win_q   <= 1'b1;
    end else if (fire) begin
      phase_q <= WDG_IDLE;
      win_q   <= 1'b1;
    end else begin
      case (phase_q)
        WDG_IDLE: begin
          if (int_done) phase_q <= WDG_RUN;
        end
        WDG_RUN: begin
          if (close_win) begin
            win_q <= 1'b0;
          end else if (dis_stb && win_q) begin
            phase_q <= WDG_OFF;
          end
        end
        WDG_OFF: begin
          if (close_win) win_q <= 1'b0;
        end
        default: phase_q <= WDG_IDLE;
      endcase
    end
  end

  // R9: with the window shut, disable leaves a running block running
  assert_shut_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !win_q && dis_stb && !fire) |=> run);

  // R10: disable coinciding with service or end-of-init is ignored
  assert_cmd_clash_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dis_stb && (svc_stb || einit_stb)) |=> !disabled);

  // R8: a disabled block stays disabled until a reset
  assert_stay_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disabled |=> disabled);

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int RL_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             svc_ok,
  input  logic             reload_we,
  input  logic [RL_W-1:0]  reload_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap,
  output logic             fire
);

  localparam int LOW_W = CNT_W - RL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [RL_W-1:0]  rl_q;
  logic [CNT_W-1:0] seed_val;

  assign seed_val = CNT_W'(wdg_seed(32'(rl_q), LOW_W));
  assign wrap     = tick && wdg_at_top(32'(cnt_q), CNT_W);
  assign fire     = wrap && !svc_ok;
  assign count    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rl_q  <= '0;
    end else if (fire) begin
      cnt_q <= '0;
      rl_q  <= '0;
    end else begin
      if (reload_we) rl_q <= reload_val;
      if (svc_ok) begin
        cnt_q <= seed_val;
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R1 / R8: no advance while idle or disabled unless a service reloads
  assert_hold_when_stopped_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !svc_ok) |=> $stable(count));

  // R7: a reload write alone never moves the count
  assert_write_no_touch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_we && !tick && !svc_ok) |=> $stable(count));

  // R6: service loads the previously held reload value
  assert_svc_seed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    svc_ok |=> (count == CNT_W'(wdg_seed(32'($past(rl_q)), LOW_W))));

  // R4: overflow leaves the count at zero
  assert_fire_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (count == '0));

endmodule

// File: rtl/wdg_cause.sv
module wdg_cause (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic svc_ok,
  output logic flag
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (fire) begin
      flag_q <= 1'b1;
    end else if (svc_ok) begin
      flag_q <= 1'b0;
    end
  end

  assign flag = flag_q;

  // R5: only service or external reset drop the flag
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !svc_ok) |=> flag_q);

endmodule

// File: rtl/wdg_top.sv
module wdg_top #(
  parameter int CNT_W = 16,
  parameter int RL_W  = 8,
  parameter int DIV   = 2
) (
  input  logic             clk,
  input  logic             ext_rst_n,
  input  logic             int_done,
  input  logic             svc_stb,
  input  logic             einit_stb,
  input  logic             dis_stb,
  input  logic             reload_we,
  input  logic [RL_W-1:0]  reload_val,
  output logic             rst_req,
  output logic             cause_flag,
  output logic [CNT_W-1:0] count
);

  logic started;
  logic disabled;
  logic window_open;
  logic svc_ok;
  logic run;
  logic tick;
  logic wrap;
  logic fire;
  logic req_q;

  wdg_permit u_permit (
    .clk         (clk),
    .rst_n       (ext_rst_n),
    .int_done    (int_done),
    .svc_stb     (svc_stb),
    .einit_stb   (einit_stb),
    .dis_stb     (dis_stb),
    .fire        (fire),
    .started     (started),
    .disabled    (disabled),
    .window_open (window_open),
    .svc_ok      (svc_ok),
    .run         (run)
  );

  wdg_prescale #(.DIV(DIV)) u_prescale (
    .clk   (clk),
    .rst_n (ext_rst_n),
    .run   (run),
    .clear (svc_ok || fire),
    .tick  (tick)
  );

  wdg_counter #(.CNT_W(CNT_W), .RL_W(RL_W)) u_counter (
    .clk        (clk),
    .rst_n      (ext_rst_n),
    .tick       (tick),
    .run        (run),
    .svc_ok     (svc_ok),
    .reload_we  (reload_we),
    .reload_val (reload_val),
    .count      (count),
    .wrap       (wrap),
    .fire       (fire)
  );

  wdg_cause u_cause (
    .clk    (clk),
    .rst_n  (ext_rst_n),
    .fire   (fire),
    .svc_ok (svc_ok),
    .flag   (cause_flag)
  );

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) req_q <= 1'b0;
    else            req_q <= fire;
  end

  assign rst_req = req_q;

  // R4: request lasts a single cycle
  assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!ext_rst_n)
    rst_req |=> !rst_req);

  // R4: request always comes with the cause flag
  assert_req_flag_R4: assert property (@(posedge clk) disable iff (!ext_rst_n)
    rst_req |-> cause_flag);

  // R4: after the request the window is open and the block enabled
  assert_req_reopen_R4: assert property (@(posedge clk) disable iff (!ext_rst_n)
    rst_req |-> (window_open && !disabled));

  // R5: accepted service clears the flag
  assert_svc_clear_R5: assert property (@(posedge clk) disable iff (!ext_rst_n)
    svc_ok |=> !cause_flag);

  // R8: a disabled block never requests a reset
  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!ext_rst_n)
    disabled |=> !rst_req);

  // R11: service on the wrapping tick suppresses the request
  assert_svc_wins_R11: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (wrap && svc_ok) |=> !rst_req);

  // R12: nothing is requested before start
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!ext_rst_n)
    !started |=> !rst_req);

endmodule

// File: tb/tb_wdg_top.sv
module tb_wdg_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        ext_rst_n = 1'b0;
  logic        int_done = 1'b0;
  logic        svc_stb = 1'b0;
  logic        einit_stb = 1'b0;
  logic        dis_stb = 1'b0;
  logic        reload_we = 1'b0;
  logic [7:0]  reload_val = 8'h00;
  logic        rst_req;
  logic        cause_flag;
  logic [15:0] count;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdg_top dut (
    .clk        (clk),
    .ext_rst_n  (ext_rst_n),
    .int_done   (int_done),
    .svc_stb    (svc_stb),
    .einit_stb  (einit_stb),
    .dis_stb    (dis_stb),
    .reload_we  (reload_we),
    .reload_val (reload_val),
    .rst_req    (rst_req),
    .cause_flag (cause_flag),
    .count      (count)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Edges from a reference edge until rst_req is seen at a negedge.
  function automatic int wrap_edges(input int rl);
    return 2 * (65536 - 256 * rl);
  endfunction

  task automatic wait_req(input int limit, inout int n);
    while (!rst_req && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_svc();
    svc_stb = 1'b1; @(negedge clk); svc_stb = 1'b0;
  endtask

  task automatic pulse_einit();
    einit_stb = 1'b1; @(negedge clk); einit_stb = 1'b0;
  endtask

  task automatic pulse_dis();
    dis_stb = 1'b1; @(negedge clk); dis_stb = 1'b0;
  endtask

  task automatic write_rl(input logic [7:0] v);
    reload_val = v; reload_we = 1'b1; @(negedge clk); reload_we = 1'b0;
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R3 watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int c;
    bit seen;

    // External reset state (R13)
    repeat (3) @(negedge clk);
    chk("R13 count in reset", count, 0);
    chk("R13 flag in reset", cause_flag, 0);
    chk("R13 req in reset", rst_req, 0);
    ext_rst_n = 1'b1;

    // Idle before start, commands ignored (R1, R12)
    repeat (20) @(negedge clk);
    pulse_svc();
    pulse_dis();
    repeat (5) @(negedge clk);
    chk("R1 idle count holds", count, 0);
    chk("R12 idle no req", rst_req, 0);

    // Start, half-rate counting, reload write mid-run (R2, R7)
    int_done = 1'b1;
    @(negedge clk);
    n = 0;
    while (n < 40) begin
      chk($sformatf("R2 count at edge %0d", n), count, n / 2);
      if (n == 10) begin reload_val = 8'h55; reload_we = 1'b1; end
      if (n == 11) reload_we = 1'b0;
      if (n == 13) chk("R7 write keeps count", count, 6);
      @(negedge clk);
      n++;
    end

    // Full default interval (R3), request shape (R4)
    wait_req(140000, n);
    chk("R3 default interval", n, 131072);
    chk("R4 flag with req", cause_flag, 1);
    chk("R4 count zero at req", count, 0);
    int_done = 1'b0;
    @(negedge clk);
    chk("R4 req single cycle", rst_req, 0);
    repeat (10) @(negedge clk);
    chk("R1 holds after self reset", count, 0);
    chk("R5 flag kept over own restart", cause_flag, 1);

    // Commands before start ignored (R12)
    pulse_svc();
    chk("R12 service before start keeps flag", cause_flag, 1);

    // Start, end-of-init closes window (R5, R9)
    int_done = 1'b1;
    repeat (4) @(negedge clk);
    pulse_einit();
    chk("R5 einit keeps flag", cause_flag, 1);
    pulse_dis();
    c = count;
    repeat (4) @(negedge clk);
    chk("R9 disable ignored after einit", count, c + 2);
    pulse_svc();
    chk("R5 service clears flag", cause_flag, 0);
    chk("R6 service loads zero reload", count, 0);

    // Reload sweep (R6)
    for (int r = 8'hF8; r <= 8'hFF; r++) begin
      write_rl(8'(r));
      pulse_svc();
      chk($sformatf("R6 seed for %0h", r), count, r * 256);
      n = 0;
      wait_req(20000, n);
      chk($sformatf("R6 interval for %0h", r), n, wrap_edges(r));
      chk("R4 flag after sweep req", cause_flag, 1);
    end

    // Window reopened after own reset; disable freezes (R4, R8)
    @(negedge clk);
    chk("R4 restarted from zero", count, 0);
    pulse_dis();
    c = count;
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (rst_req) seen = 1;
    end
    chk("R8 count frozen", count, c);
    chk("R8 no request while off", seen, 0);
    write_rl(8'h12);
    pulse_svc();
    chk("R8 service reloads while off", count, 16'h1200);
    chk("R8 service clears flag while off", cause_flag, 0);
    repeat (20) @(negedge clk);
    chk("R8 still frozen after service", count, 16'h1200);

    // External reset clears disabled state and reload (R13)
    ext_rst_n = 1'b0;
    @(negedge clk);
    chk("R13 count cleared", count, 0);
    chk("R13 flag cleared", cause_flag, 0);
    ext_rst_n = 1'b1;
    @(negedge clk);
    repeat (6) @(negedge clk);
    chk("R13 counting again", count, 3);

    // Disable together with service ignored (R10)
    svc_stb = 1'b1; dis_stb = 1'b1;
    @(negedge clk);
    svc_stb = 1'b0; dis_stb = 1'b0;
    chk("R13 reload cleared by ext reset", count, 0);
    repeat (6) @(negedge clk);
    chk("R10 clash leaves block running", count, 3);

    // Service on the wrapping tick wins (R11)
    write_rl(8'hFF);
    pulse_svc();
    n = 0;
    while (n < 511) begin @(negedge clk); n++; end
    svc_stb = 1'b1;
    @(negedge clk);
    svc_stb = 1'b0;
    chk("R11 no request on clash", rst_req, 0);
    chk("R11 count reloaded", count, 16'hFF00);
    n = 0;
    wait_req(2000, n);
    chk("R11 next interval", n, 512);
    chk("R4 flag on later req", cause_flag, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule